// File: doc/BRIEF.md
# Fully Associative Data Translation Buffer

This block translates data virtual addresses into physical addresses through a small, software-filled translation cache of 32 entries. Each entry pairs a 21-bit virtual page tag with a 21-bit physical frame number and carries two 2-bit permission fields, one for loads and one for stores. A lookup compares the tag against every entry at once. The frame of the matching entry is joined to the untouched 13-bit page offset to form a 34-bit physical address. When the matching entry lacks the permission that the access needs in the current privilege mode, the lookup reports a protection fault and no hit.

The refill handler writes entries through an insert port. The block picks the slot: the lowest-numbered free slot when one exists, otherwise the slot named by a free-running counter. A single-cycle invalidate-all input empties the buffer. Results are registered, so each lookup answers exactly one cycle after it is presented.

The response is held in a small result-state register with four states. RES_IDLE means no response this cycle. RES_MISS means no valid entry matched. RES_HIT means a match with permission granted. RES_FAULT means a match with permission denied. Every cycle the register moves to one of these states from the current lookup inputs. With no request it moves to RES_IDLE. With a request and no match it moves to RES_MISS. With a match it moves to RES_HIT or RES_FAULT, depending on the permission check. Any state may follow any other.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset every entry is invalid and no response is presented (rsp_valid, rsp_hit, rsp_fault low, rsp_paddr zero); a lookup issued before any insert misses.
- R2: A lookup presented with lk_valid in cycle N whose address bits [33:13] equal the tag of a valid entry, with permission granted, gives rsp_valid=1 and rsp_hit=1 in cycle N+1.
- R3: On a hit rsp_paddr[33:13] is the entry's frame number and rsp_paddr[12:0] equals lk_vaddr[12:0] of the request; whenever rsp_hit is low rsp_paddr is zero.
- R4: A lookup matching no valid entry gives rsp_valid=1, rsp_hit=0, rsp_fault=0.
- R5: Permission uses the read field for lk_write=0 and the write field for lk_write=1. Bit 0 of a field grants kernel access (lk_user=0) and bit 1 grants user access (lk_user=1). A matching lookup whose needed bit is clear gives rsp_fault=1 and rsp_hit=0.
- R6: When several valid entries match, the lowest-numbered one supplies the frame and the permission.
- R7: An insert writes tag, frame and both fields into the lowest-numbered invalid slot when any slot is invalid, and marks it valid.
- R8: When all slots are valid, an insert replaces the slot given by a 5-bit counter that is zero during reset and advances by one on every clock edge after reset.
- R9: flush_all invalidates all entries at one clock edge, and it takes precedence over an insert in the same cycle (that insert is dropped).
- R10: A lookup in the same cycle as an insert or a flush is answered from the contents held before that clock edge.
- R11: rsp_valid is high in a cycle exactly when lk_valid was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 34 | Virtual address: [33:13] tag, [12:0] offset |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ins_en | input | 1 | Write one entry this cycle |
| ins_tag | input | 21 | Tag of the new entry |
| ins_ppn | input | 21 | Physical frame number of the new entry |
| ins_rd | input | 2 | Read permission field (bit 0 kernel, bit 1 user) |
| ins_wr | input | 2 | Write permission field (bit 0 kernel, bit 1 user) |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after lk_valid) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Entry matched but permission denied |
| rsp_paddr | output | 34 | Physical address on hit, zero otherwise |

## Verification
A stale or corrupted valid bit shows up at the next lookup of the affected tag as a wrong hit or a wrong miss, one cycle after the request. A wrong victim choice does not show when it happens. It shows only later, when a lookup of the entry that should have survived misses, or a lookup of the entry that should have been evicted hits. For that reason the stimulus fills the buffer completely and then looks up every resident tag. Misordered priority among duplicate tags shows as the wrong frame or the wrong permission on the very next lookup.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    // registered result of one lookup
    typedef enum logic [1:0] {
        RES_IDLE,
        RES_MISS,
        RES_HIT,
        RES_FAULT
    } res_e;

    // bit positions inside a 2-bit permission field
    localparam int PERM_KERNEL = 0;
    localparam int PERM_USER   = 1;
endpackage

// File: rtl/dtlb_pick.sv
// Lowest-index one-hot selection out of a request vector.
module dtlb_pick #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant_oh,
    output logic         any
);
    always_comb begin
        logic found;
        found    = 1'b0;
        grant_oh = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    assign any = |req;

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh)); // R6
    AST_PICK_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_oh & ~req) == '0); // R6
endmodule

// File: rtl/dtlb_match.sv
// Parallel tag compare against every entry.
module dtlb_match #(
    parameter int N     = 32,
    parameter int TAG_W = 21
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/dtlb_victim.sv
// Slot choice for an insert: first free slot, else a free-running counter.
module dtlb_victim #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] cnt_q;
    logic [N-1:0]     free_oh;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    dtlb_pick #(.N(N)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (~vld),
        .grant_oh (free_oh),
        .any      (any_free)
    );

    always_comb begin
        free_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (free_oh[i]) free_idx = free_idx | IDX_W'(i);
        end
    end

    assign victim = any_free ? free_idx : cnt_q;

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !vld[victim]); // R7
    AST_VICTIM_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !any_free |=> (victim == $past(cnt_q) + 1'b1) || any_free); // R8
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 21,
    parameter int OFF_W   = 13,
    parameter int PPN_W   = 21,
    parameter int PROT_W  = 2,
    localparam int VA_W  = TAG_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              ins_en,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [PROT_W-1:0] ins_rd,
    input  logic [PROT_W-1:0] ins_wr,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr
);
    // entry storage
    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0][PROT_W-1:0] rd_q;
    logic [ENTRIES-1:0][PROT_W-1:0] wr_q;

    logic [IDX_W-1:0]   victim;
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] hit_oh;
    logic               hit_any;
    logic [PPN_W-1:0]   ppn_sel;
    logic [PROT_W-1:0]  rd_sel;
    logic [PROT_W-1:0]  wr_sel;
    logic               perm_ok;
    res_e               res_d, res_q;
    logic [PA_W-1:0]    paddr_q;

    // ---------------- fill and invalidate ----------------
    dtlb_victim #(.N(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (vld_q),
        .victim (victim)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         vld_q <= '0;
        else if (flush_all) vld_q <= '0;
        else if (ins_en)    vld_q[victim] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush_all) begin
            tag_q[victim] <= ins_tag;
            ppn_q[victim] <= ins_ppn;
            rd_q[victim]  <= ins_rd;
            wr_q[victim]  <= ins_wr;
        end
    end

    // ---------------- lookup ----------------
    dtlb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_match (
        .vld  (vld_q),
        .tags (tag_q),
        .key  (lk_vaddr[VA_W-1:OFF_W]),
        .hits (hits)
    );

    dtlb_pick #(.N(ENTRIES)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (hits),
        .grant_oh (hit_oh),
        .any      (hit_any)
    );

    // one-hot AND-OR selection of frame and permission fields
    always_comb begin
        ppn_sel = '0;
        rd_sel  = '0;
        wr_sel  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_oh[i]) begin
                ppn_sel = ppn_sel | ppn_q[i];
                rd_sel  = rd_sel  | rd_q[i];
                wr_sel  = wr_sel  | wr_q[i];
            end
        end
    end

    always_comb begin
        if (lk_user) perm_ok = lk_write ? wr_sel[PERM_USER]   : rd_sel[PERM_USER];
        else         perm_ok = lk_write ? wr_sel[PERM_KERNEL] : rd_sel[PERM_KERNEL];
    end

    // next result state
    always_comb begin
        if (!lk_valid)     res_d = RES_IDLE;
        else if (!hit_any) res_d = RES_MISS;
        else if (perm_ok)  res_d = RES_HIT;
        else               res_d = RES_FAULT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= RES_IDLE;
            paddr_q <= '0;
        end else begin
            res_q   <= res_d;
            paddr_q <= (res_d == RES_HIT) ? {ppn_sel, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_fault = 1'b0;
        unique case (res_q)
            RES_IDLE:  ;
            RES_MISS:  rsp_valid = 1'b1;
            RES_HIT:   begin rsp_valid = 1'b1; rsp_hit   = 1'b1; end
            RES_FAULT: begin rsp_valid = 1'b1; rsp_fault = 1'b1; end
        endcase
    end
    assign rsp_paddr = paddr_q;

    // ---------------- assertions ----------------
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R11
    AST_PADDR_ZERO_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0)); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R3
    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && hits == '0) |=> (rsp_valid && !rsp_hit && !rsp_fault)); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_q == '0)); // R9
    AST_INSERT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush_all) |=> vld_q[$past(victim)]); // R7
endmodule

// File: tb/dtlb_xlate_bench.sv
`timescale 1ns/1ps
module dtlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [33:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        ins_en = 1'b0;
    logic [20:0] ins_tag = '0;
    logic [20:0] ins_ppn = '0;
    logic [1:0]  ins_rd = '0;
    logic [1:0]  ins_wr = '0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [33:0] rsp_paddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dtlb_xlate u_dtlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .ins_en(ins_en), .ins_tag(ins_tag), .ins_ppn(ins_ppn), .ins_rd(ins_rd), .ins_wr(ins_wr),
        .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // reference model
    bit          m_vld [32];
    logic [20:0] m_tag [32];
    logic [20:0] m_ppn [32];
    logic [1:0]  m_rd  [32];
    logic [1:0]  m_wr  [32];
    logic [4:0]  m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_cnt <= '0;
        else        m_cnt <= m_cnt + 5'd1;
    end

    // expected result: 0 idle, 1 miss, 2 hit, 3 fault
    function automatic int exp_lookup(input logic [33:0] va, input bit wr, input bit usr,
                                      output logic [33:0] pa);
        int idx;
        bit ok;
        idx = -1;
        pa  = '0;
        for (int i = 0; i < 32; i++)
            if (idx < 0 && m_vld[i] && m_tag[i] == va[33:13]) idx = i;
        if (idx < 0) return 1;
        ok = wr ? m_wr[idx][usr] : m_rd[idx][usr];
        if (!ok) return 3;
        pa = {m_ppn[idx], va[12:0]};
        return 2;
    endfunction

    function automatic int pick_slot();
        for (int i = 0; i < 32; i++)
            if (!m_vld[i]) return i;
        return int'(m_cnt);
    endfunction

    task automatic run_op(input bit lk, input logic [33:0] va, input bit wr, input bit usr,
                          input bit ins, input logic [20:0] itag, input logic [20:0] ippn,
                          input logic [1:0] ird, input logic [1:0] iwr, input bit fl,
                          input string req);
        int exp_res;
        int slot;
        logic [33:0] exp_pa;
        @(negedge clk);
        lk_valid = lk; lk_vaddr = va; lk_write = wr; lk_user = usr;
        ins_en = ins; ins_tag = itag; ins_ppn = ippn; ins_rd = ird; ins_wr = iwr;
        flush_all = fl;
        exp_pa = '0;
        exp_res = lk ? exp_lookup(va, wr, usr, exp_pa) : 0;
        if (fl) begin
            for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
        end else if (ins) begin
            slot = pick_slot();
            m_vld[slot] = 1'b1; m_tag[slot] = itag; m_ppn[slot] = ippn;
            m_rd[slot] = ird; m_wr[slot] = iwr;
        end
        @(negedge clk);
        lk_valid = 1'b0; ins_en = 1'b0; flush_all = 1'b0;
        n_chk++;
        if (rsp_valid !== (exp_res != 0) || rsp_hit !== (exp_res == 2) ||
            rsp_fault !== (exp_res == 3) || rsp_paddr !== exp_pa) begin
            n_fail++;
            $display("FAIL %s: got v=%b h=%b f=%b pa=%h, expected v=%b h=%b f=%b pa=%h",
                     req, rsp_valid, rsp_hit, rsp_fault, rsp_paddr,
                     exp_res != 0, exp_res == 2, exp_res == 3, exp_pa);
        end
    endtask

    task automatic lookup(input logic [20:0] tag, input logic [12:0] off, input bit wr,
                          input bit usr, input string req);
        run_op(1'b1, {tag, off}, wr, usr, 1'b0, '0, '0, '0, '0, 1'b0, req);
    endtask

    task automatic insert(input logic [20:0] tag, input logic [20:0] ppn,
                          input logic [1:0] rd, input logic [1:0] wr, input string req);
        run_op(1'b0, '0, 1'b0, 1'b0, 1'b1, tag, ppn, rd, wr, 1'b0, req);
    endtask

    task automatic flush(input string req);
        run_op(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, 1'b1, req);
    endtask

    function automatic logic [20:0] fill_tag(input int k);
        return 21'(k * 2113 + 17);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected run to finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0 || rsp_paddr !== '0) begin
            n_fail++;
            $display("FAIL R1: got v=%b h=%b f=%b pa=%h, expected all zero",
                     rsp_valid, rsp_hit, rsp_fault, rsp_paddr);
        end
        lookup(21'h0, 13'h0, 1'b0, 1'b0, "R1");
        lookup(21'h1ABCD, 13'h123, 1'b0, 1'b1, "R1");

        // R2 / R3: basic hit, offset passthrough
        insert(21'h0AAAA, 21'h15555, 2'b11, 2'b11, "R7");
        lookup(21'h0AAAA, 13'h1FFF, 1'b0, 1'b0, "R2");
        lookup(21'h0AAAA, 13'h0001, 1'b1, 1'b1, "R3");
        // R4: miss
        lookup(21'h0AAAB, 13'h0042, 1'b0, 1'b0, "R4");

        // R5: permission fields, bit0 kernel, bit1 user
        insert(21'h00B0B, 21'h00777, 2'b01, 2'b00, "R7");
        lookup(21'h00B0B, 13'h0010, 1'b0, 1'b1, "R5");
        lookup(21'h00B0B, 13'h0010, 1'b0, 1'b0, "R5");
        lookup(21'h00B0B, 13'h0010, 1'b1, 1'b0, "R5");
        insert(21'h00C0C, 21'h00888, 2'b10, 2'b10, "R7");
        lookup(21'h00C0C, 13'h0ABC, 1'b1, 1'b1, "R5");
        lookup(21'h00C0C, 13'h0ABC, 1'b1, 1'b0, "R5");

        // R6: duplicate tag, lowest index wins (frame and permission)
        insert(21'h0AAAA, 21'h1F0F0, 2'b00, 2'b00, "R6");
        lookup(21'h0AAAA, 13'h0777, 1'b0, 1'b1, "R6");

        // R10: lookup in the same cycle as an insert sees old contents
        run_op(1'b1, {21'h0D0D0, 13'h5}, 1'b0, 1'b0, 1'b1, 21'h0D0D0, 21'h0CAFE,
               2'b11, 2'b11, 1'b0, "R10");
        lookup(21'h0D0D0, 13'h5, 1'b0, 1'b0, "R10");

        // R10: lookup in the same cycle as a flush sees old contents
        run_op(1'b1, {21'h0D0D0, 13'h6}, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, 1'b1, "R10");
        lookup(21'h0D0D0, 13'h6, 1'b0, 1'b0, "R9");

        // R9: flush beats a same-cycle insert
        insert(21'h0EEEE, 21'h01234, 2'b11, 2'b11, "R7");
        run_op(1'b0, '0, 1'b0, 1'b0, 1'b1, 21'h0F00F, 21'h04321, 2'b11, 2'b11, 1'b1, "R9");
        lookup(21'h0F00F, 13'h0, 1'b0, 1'b0, "R9");
        lookup(21'h0EEEE, 13'h0, 1'b0, 1'b0, "R9");

        // R7 / R8: fill completely, then replace by counter
        for (int k = 0; k < 32; k++) insert(fill_tag(k), 21'(k + 100), 2'b11, 2'b11, "R7");
        for (int k = 0; k < 32; k++) lookup(fill_tag(k), 13'(k), 1'b0, 1'b0, "R7");
        insert(fill_tag(32), 21'h1BEEF, 2'b11, 2'b11, "R8");
        for (int k = 0; k <= 32; k++) lookup(fill_tag(k), 13'(k), 1'b0, 1'b1, "R8");
        insert(fill_tag(33), 21'h1FEED, 2'b11, 2'b01, "R8");
        for (int k = 0; k <= 33; k++) lookup(fill_tag(k), 13'(k), 1'b1, 1'b0, "R8");

        // R11: no request, no response
        run_op(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, 1'b0, "R11");

        // constrained random mix
        void'($urandom(32'd7321));
        for (int n = 0; n < 3000; n++) begin
            bit fl, ins, lk;
            logic [20:0] t1, t2;
            fl  = ($urandom % 64) == 0;
            ins = ($urandom % 3) == 0;
            lk  = ($urandom % 4) != 0;
            t1  = fill_tag(int'($urandom % 40));
            t2  = fill_tag(int'($urandom % 40));
            run_op(lk, {t1, 13'($urandom)}, 1'($urandom), 1'($urandom),
                   ins, t2, 21'($urandom), 2'($urandom), 2'($urandom), fl, "R5");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule